// File: doc/BRIEF.md
# PCIe MSI Capture Controller

This block sits beside a PCIe root port and turns inbound message-signalled interrupts into a single interrupt line for the host CPU. The port logic presents each inbound memory write on a sideband: a one-cycle valid strobe with a 64-bit address and 32-bit data. When the address equals the programmed 64-bit target, the low bits of the data select a vector. If that vector is enabled, its pending flag is set.

Vectors are organised in groups of 32. Each group has an enable word, a mask word and a pending-status word. Software programs the target address and the enables through a 32-bit word-wide register port. It sees a combined interrupt when any unmasked vector is pending, and acknowledges vectors by writing ones to the status word. The group count is a parameter, 8 by default (256 vectors).

Top module: `msi_capture_unit`

## Requirements
- R1: After reset, every enable, mask and status bit and both halves of the target address read as 0, and `msiIrq` is low.
- R2: The target address low word sits at offset 0x820 and the high word at 0x824. Both are read/write and together form the 64-bit match address.
- R3: The registers of group g start at offset 0x828 + 12*g, with enable at +0, mask at +4 and status at +8. Enable and mask read back the last value written.
- R4: An inbound write whose address equals the target sets status bit n mod 32 of group n/32. Here n is the low 8 bits of the write data (with 8 groups); the upper data bits are ignored. This holds only when that vector's enable bit is 1, and vector 255 maps to bit 31 of group 7.
- R5: An inbound write whose address differs from the target in either 32-bit half changes no status bit.
- R6: An inbound write to the target for a vector whose enable bit is 0 changes no status bit.
- R7: Writing to a status register clears each bit written as 1 and leaves each bit written as 0 unchanged. Software cannot set a status bit.
- R8: `msiIrq` is high exactly while some status bit is 1 with its mask bit 0. Masking a vector does not clear its status.
- R9: If an inbound write sets a vector in the same cycle that software writes 1 to clear that vector's status bit, the bit ends up set.
- R10: An access whose address has bits [1:0] not equal to 0 is rejected. A rejected write changes nothing, a rejected read returns 0, and `regErr` is 1 in the cycle after either kind of rejected access.
- R11: Aligned offsets that map to no register read as 0, ignore writes and do not raise `regErr`.
- R12: Read data and `regErr` appear one clock after the access strobe. A status bit set by an inbound write is visible, together with the resulting `msiIrq`, one clock after `msiValid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | ADDR_W (12) | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data, one cycle after `regRdEn` |
| regErr | output | 1 | Misaligned-access flag, one cycle after the access |
| msiValid | input | 1 | Inbound memory write valid, one cycle per write |
| msiAddr | input | 64 | Inbound write address |
| msiData | input | 32 | Inbound write data; the low bits give the vector |
| msiIrq | output | 1 | Combined interrupt to the host CPU |

## Verification
The assertions assume the following about the inputs:
- Reset is held from time zero until the first clock edges have passed.
- Every strobe, address and data input has a known value at each rising edge.
- Each inbound write is a single-cycle `msiValid` pulse.

The stimulus changes inputs only on falling clock edges and presents one register transaction per strobe. It keeps `msiValid` low except for the single cycle of each inbound write. The one deliberate overlap is an inbound write issued in the same cycle as a write-one-to-clear of the same status bit.

// File: rtl/msi_cap_pkg.sv
`timescale 1ns/1ps
package msi_cap_pkg;
  localparam logic [11:0] TGT_LO_OFS   = 12'h820;
  localparam logic [11:0] TGT_HI_OFS   = 12'h824;
  localparam logic [11:0] GRP_BASE_OFS = 12'h828;
  localparam int GRP_STRIDE  = 12;
  localparam int VEC_PER_GRP = 32;
  localparam int GRP_IDX_W   = 8;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_TGT_LO, SEL_TGT_HI, SEL_ENABLE, SEL_MASK, SEL_STATUS
  } regSel_e;

  // strobes handed from the decoder to the datapath
  typedef struct packed {
    logic                 wrStrobe;
    logic                 rdStrobe;
    regSel_e              sel;
    logic [GRP_IDX_W-1:0] grpIdx;
  } regCmd_t;
endpackage

// File: rtl/msi_cap_decode.sv
`timescale 1ns/1ps
module msi_cap_decode
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  output regCmd_t           cmd,
  output logic              regErr
);
  logic badAlign;
  logic errQ;

  assign badAlign = (regAddr[1:0] != 2'b00);

  always_comb begin
    cmd          = '0;
    cmd.sel      = SEL_NONE;
    cmd.wrStrobe = regWrEn & ~badAlign;
    cmd.rdStrobe = regRdEn;
    if (!badAlign) begin
      if (regAddr == ADDR_W'(TGT_LO_OFS)) cmd.sel = SEL_TGT_LO;
      if (regAddr == ADDR_W'(TGT_HI_OFS)) cmd.sel = SEL_TGT_HI;
      for (int g = 0; g < NUM_GROUPS; g++) begin
        if (regAddr == ADDR_W'(int'(GRP_BASE_OFS) + g*GRP_STRIDE)) begin
          cmd.sel = SEL_ENABLE; cmd.grpIdx = GRP_IDX_W'(g);
        end
        if (regAddr == ADDR_W'(int'(GRP_BASE_OFS) + g*GRP_STRIDE + 4)) begin
          cmd.sel = SEL_MASK; cmd.grpIdx = GRP_IDX_W'(g);
        end
        if (regAddr == ADDR_W'(int'(GRP_BASE_OFS) + g*GRP_STRIDE + 8)) begin
          cmd.sel = SEL_STATUS; cmd.grpIdx = GRP_IDX_W'(g);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) errQ <= 1'b0;
    else       errQ <= (regWrEn | regRdEn) & badAlign;
  end

  assign regErr = errQ;
endmodule

// File: rtl/msi_cap_datapath.sv
`timescale 1ns/1ps
module msi_cap_datapath
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  localparam int NUM_VEC   = NUM_GROUPS * VEC_PER_GRP,
  localparam int VEC_W     = $clog2(NUM_VEC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  regCmd_t            cmd,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic               msiValid,
  input  logic [63:0]        msiAddr,
  input  logic [31:0]        msiData,
  output logic [NUM_VEC-1:0] enableVec,
  output logic [NUM_VEC-1:0] maskVec,
  output logic [NUM_VEC-1:0] statusVec,
  output logic               msiIrq
);
  logic [63:0]        targetQ;
  logic [NUM_VEC-1:0] enableQ, maskQ, statusQ;
  logic [NUM_VEC-1:0] enableD, maskD, statusD;
  logic [NUM_VEC-1:0] setVec, clrVec;
  logic [31:0]        rdMux, rdQ;
  logic               vecHit;
  logic [VEC_W-1:0]   vecNum;
  logic               unusedDataBits;

  assign vecNum         = msiData[VEC_W-1:0];
  assign unusedDataBits = ^msiData[31:VEC_W];
  assign vecHit         = msiValid && (msiAddr == targetQ);
  assign setVec         = vecHit ? ((NUM_VEC'(1) << vecNum) & enableQ) : '0;

  always_comb begin
    enableD = enableQ;
    maskD   = maskQ;
    clrVec  = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (cmd.wrStrobe && cmd.grpIdx == GRP_IDX_W'(g)) begin
        if (cmd.sel == SEL_ENABLE) enableD[g*VEC_PER_GRP +: VEC_PER_GRP] = regWrData;
        if (cmd.sel == SEL_MASK)   maskD[g*VEC_PER_GRP +: VEC_PER_GRP]   = regWrData;
        if (cmd.sel == SEL_STATUS) clrVec[g*VEC_PER_GRP +: VEC_PER_GRP]  = regWrData;
      end
    end
    // a new event overrides an acknowledge of the same bit
    statusD = (statusQ & ~clrVec) | setVec;
  end

  always_comb begin
    rdMux = '0;
    case (cmd.sel)
      SEL_TGT_LO: rdMux = targetQ[31:0];
      SEL_TGT_HI: rdMux = targetQ[63:32];
      SEL_ENABLE, SEL_MASK, SEL_STATUS: begin
        for (int g = 0; g < NUM_GROUPS; g++) begin
          if (cmd.grpIdx == GRP_IDX_W'(g)) begin
            if (cmd.sel == SEL_ENABLE) rdMux = enableQ[g*VEC_PER_GRP +: VEC_PER_GRP];
            if (cmd.sel == SEL_MASK)   rdMux = maskQ[g*VEC_PER_GRP +: VEC_PER_GRP];
            if (cmd.sel == SEL_STATUS) rdMux = statusQ[g*VEC_PER_GRP +: VEC_PER_GRP];
          end
        end
      end
      default: rdMux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      targetQ <= '0;
      enableQ <= '0;
      maskQ   <= '0;
      statusQ <= '0;
      rdQ     <= '0;
    end else begin
      if (cmd.wrStrobe && cmd.sel == SEL_TGT_LO) targetQ[31:0]  <= regWrData;
      if (cmd.wrStrobe && cmd.sel == SEL_TGT_HI) targetQ[63:32] <= regWrData;
      enableQ <= enableD;
      maskQ   <= maskD;
      statusQ <= statusD;
      rdQ     <= cmd.rdStrobe ? rdMux : 32'h0;
    end
  end

  assign regRdData = rdQ;
  assign enableVec = enableQ;
  assign maskVec   = maskQ;
  assign statusVec = statusQ;
  assign msiIrq    = |(statusQ & ~maskQ);
endmodule

// File: rtl/msi_capture_unit.sv
`timescale 1ns/1ps
module msi_capture_unit
  import msi_cap_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 12,
  localparam int NUM_VEC   = NUM_GROUPS * VEC_PER_GRP
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [31:0]       regWrData,
  output logic [31:0]       regRdData,
  output logic              regErr,
  input  logic              msiValid,
  input  logic [63:0]       msiAddr,
  input  logic [31:0]       msiData,
  output logic              msiIrq
);
  regCmd_t            cmd;
  logic [NUM_VEC-1:0] enableVec, maskVec, statusVec;

  msi_cap_decode #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) decode_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .cmd(cmd), .regErr(regErr)
  );

  msi_cap_datapath #(.NUM_GROUPS(NUM_GROUPS)) datapath_i (
    .clk(clk), .rstN(rstN), .cmd(cmd), .regWrData(regWrData),
    .regRdData(regRdData), .msiValid(msiValid), .msiAddr(msiAddr),
    .msiData(msiData), .enableVec(enableVec), .maskVec(maskVec),
    .statusVec(statusVec), .msiIrq(msiIrq)
  );
endmodule

// File: rtl/msi_cap_chk.sv
`timescale 1ns/1ps
module msi_cap_chk #(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 12,
  localparam int NUM_VEC   = NUM_GROUPS * 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic               regRdEn,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [31:0]        regRdData,
  input logic               regErr,
  input logic               msiValid,
  input logic [NUM_VEC-1:0] enableVec,
  input logic [NUM_VEC-1:0] maskVec,
  input logic [NUM_VEC-1:0] statusVec
);
  // R4: a status bit only rises after an inbound write
  assert_set_needs_inbound_R4: assert property (@(posedge clk) disable iff (!rstN)
    (|(statusVec & ~$past(statusVec))) |-> $past(msiValid));

  // R4: one inbound write sets at most one vector
  assert_one_set_per_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $countones(statusVec & ~$past(statusVec)) <= 1);

  // R6: a disabled vector never becomes pending
  assert_set_needs_enable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (statusVec & ~$past(statusVec) & ~$past(enableVec)) == '0);

  // R7: status bits only fall after a register write
  assert_clear_needs_write_R7: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(statusVec) & ~statusVec)) |-> $past(regWrEn));

  // R10: a misaligned write leaves enables and masks alone
  assert_misaligned_wr_ignored_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(regWrEn && regAddr[1:0] != 2'b00) |-> ($stable(enableVec) && $stable(maskVec)));

  // R10: a misaligned read returns zero and flags an error
  assert_misaligned_rd_zero_R10: assert property (@(posedge clk) disable iff (!rstN)
    $past(regRdEn && regAddr[1:0] != 2'b00) |-> (regRdData == 32'h0 && regErr));
endmodule

bind msi_capture_unit msi_cap_chk #(.NUM_GROUPS(NUM_GROUPS), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
  .regRdData(regRdData), .regErr(regErr), .msiValid(msiValid),
  .enableVec(enableVec), .maskVec(maskVec), .statusVec(statusVec)
);

// File: tb/msi_capture_unit_tb_top.sv
`timescale 1ns/1ps
module msi_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        regErr;
  logic        msiValid = 1'b0;
  logic [63:0] msiAddr = '0;
  logic [31:0] msiData = '0;
  logic        msiIrq;

  int testCount = 0;
  int failCount = 0;
  bit done = 1'b0;

  localparam logic [63:0] TGT = 64'h0000_0001_FEE0_0000;

  always #2.5 clk = ~clk;

  msi_capture_unit dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .regErr(regErr), .msiValid(msiValid), .msiAddr(msiAddr),
    .msiData(msiData), .msiIrq(msiIrq)
  );

  function automatic logic [11:0] grpAddr(input int g, input int k);
    return 12'(12'h828 + 12*g + 4*k);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [11:0] a, input logic [31:0] d, output logic e);
    @(negedge clk); regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk); regWrEn = 1'b0; e = regErr;
  endtask

  task automatic regRead(input logic [11:0] a, output logic [31:0] d, output logic e);
    @(negedge clk); regRdEn = 1'b1; regAddr = a;
    @(negedge clk); regRdEn = 1'b0; d = regRdData; e = regErr;
  endtask

  task automatic sendMsi(input logic [63:0] a, input logic [31:0] d);
    @(negedge clk); msiValid = 1'b1; msiAddr = a; msiData = d;
    @(negedge clk); msiValid = 1'b0;
  endtask

  task automatic testReset();
    logic [31:0] d; logic e;
    check("R1 irq", msiIrq, 0);
    regRead(12'h820, d, e); check("R1 tgt lo", d, 0);
    regRead(12'h824, d, e); check("R1 tgt hi", d, 0);
    regRead(grpAddr(0, 2), d, e); check("R1 status0", d, 0);
    regRead(grpAddr(7, 1), d, e); check("R1 mask7", d, 0);
    regRead(grpAddr(3, 0), d, e); check("R1 enable3", d, 0);
  endtask

  task automatic testTarget();
    logic [31:0] d; logic e;
    regWrite(12'h820, TGT[31:0], e);
    regWrite(12'h824, TGT[63:32], e);
    regRead(12'h820, d, e); check("R2 tgt lo", d, TGT[31:0]);
    regRead(12'h824, d, e); check("R2 tgt hi", d, TGT[63:32]);
    check("R12 err on good read", e, 0);
  endtask

  task automatic testGroupRegs();
    logic [31:0] d; logic e;
    regWrite(grpAddr(5, 0), 32'h0002_0000, e);
    regWrite(grpAddr(5, 1), 32'h1234_5678, e);
    regWrite(grpAddr(0, 0), 32'h0000_0008, e);
    regRead(12'h864, d, e); check("R3 enable5 at 0x864", d, 32'h0002_0000);
    regRead(12'h868, d, e); check("R3 mask5 at 0x868", d, 32'h1234_5678);
    regRead(12'h828, d, e); check("R3 enable0", d, 32'h8);
    regWrite(grpAddr(5, 1), 32'h0, e);
  endtask

  task automatic testDelivery();
    logic [31:0] d; logic e;
    sendMsi(TGT, 32'h0000_0003);
    check("R12 irq next cycle", msiIrq, 1);
    regRead(grpAddr(0, 2), d, e); check("R4 status0 bit3", d, 32'h8);
    sendMsi(TGT, 32'hABCD_00B1);
    regRead(grpAddr(5, 2), d, e); check("R4 vec177 upper data ignored", d, 32'h0002_0000);
  endtask

  task automatic testMismatch();
    logic [31:0] d; logic e;
    regWrite(grpAddr(0, 2), 32'hFFFF_FFFF, e);
    regWrite(grpAddr(5, 2), 32'hFFFF_FFFF, e);
    sendMsi(TGT ^ 64'h1_0000_0000, 32'h3);
    sendMsi(TGT ^ 64'h4, 32'h3);
    check("R5 irq stays low", msiIrq, 0);
    regRead(grpAddr(0, 2), d, e); check("R5 status0", d, 0);
  endtask

  task automatic testDisabled();
    logic [31:0] d; logic e;
    sendMsi(TGT, 32'h4);
    regRead(grpAddr(0, 2), d, e); check("R6 disabled vec4", d, 0);
    check("R6 irq", msiIrq, 0);
  endtask

  task automatic testW1c();
    logic [31:0] d; logic e;
    sendMsi(TGT, 32'h3);
    regWrite(grpAddr(0, 2), 32'h0, e);
    regRead(grpAddr(0, 2), d, e); check("R7 zero write keeps", d, 32'h8);
    regWrite(grpAddr(0, 2), 32'hFFFF_FFF7, e);
    regRead(grpAddr(0, 2), d, e); check("R7 other ones keep bit3", d, 32'h8);
    regWrite(grpAddr(0, 2), 32'h8, e);
    regRead(grpAddr(0, 2), d, e); check("R7 one clears", d, 0);
    check("R7 irq low after ack", msiIrq, 0);
  endtask

  task automatic testMask();
    logic [31:0] d; logic e;
    sendMsi(TGT, 32'h3);
    check("R8 irq unmasked", msiIrq, 1);
    regWrite(grpAddr(0, 1), 32'h8, e);
    check("R8 irq masked", msiIrq, 0);
    regRead(grpAddr(0, 2), d, e); check("R8 status kept", d, 32'h8);
    regWrite(grpAddr(0, 1), 32'h0, e);
    check("R8 irq after unmask", msiIrq, 1);
    regWrite(grpAddr(0, 2), 32'h8, e);
  endtask

  task automatic testCollision();
    logic [31:0] d; logic e;
    @(negedge clk);
    msiValid = 1'b1; msiAddr = TGT; msiData = 32'h3;
    regWrEn = 1'b1; regAddr = grpAddr(0, 2); regWrData = 32'h8;
    @(negedge clk);
    msiValid = 1'b0; regWrEn = 1'b0;
    regRead(grpAddr(0, 2), d, e); check("R9 set wins", d, 32'h8);
    regWrite(grpAddr(0, 2), 32'h8, e);
  endtask

  task automatic testMisaligned();
    logic [31:0] d; logic e;
    regWrite(12'h82A, 32'hFFFF_FFFF, e); check("R10 write err", e, 1);
    regWrite(12'h822, 32'h0, e);         check("R10 write err lo", e, 1);
    regRead(12'h828, d, e); check("R10 enable0 unchanged", d, 32'h8);
    regRead(12'h820, d, e); check("R10 tgt lo unchanged", d, TGT[31:0]);
    regRead(12'h821, d, e); check("R10 read zero", d, 0); check("R10 read err", e, 1);
  endtask

  task automatic testUnused();
    logic [31:0] d; logic e;
    regWrite(12'h888, 32'hFFFF_FFFF, e); check("R11 no err", e, 0);
    regWrite(12'h81C, 32'hFFFF_FFFF, e);
    regRead(12'h888, d, e); check("R11 read 0x888", d, 0); check("R11 read no err", e, 0);
    regRead(12'h900, d, e); check("R11 read 0x900", d, 0);
    regRead(12'h820, d, e); check("R11 tgt lo intact", d, TGT[31:0]);
    regRead(grpAddr(7, 0), d, e); check("R11 enable7 intact", d, 0);
  endtask

  task automatic testTopVector();
    logic [31:0] d; logic e;
    regWrite(12'h87C, 32'h8000_0000, e);
    sendMsi(TGT, 32'h0000_00FF);
    regRead(12'h884, d, e); check("R4 vec255 group7 bit31", d, 32'h8000_0000);
    check("R8 irq from group7", msiIrq, 1);
    regWrite(12'h884, 32'h8000_0000, e);
    check("R7 irq cleared group7", msiIrq, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testTarget();
    testGroupRegs();
    testDelivery();
    testMismatch();
    testDisabled();
    testW1c();
    testMask();
    testCollision();
    testMisaligned();
    testUnused();
    testTopVector();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      testCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end
endmodule